// File: doc/BRIEF.md
# Capability-checked address generator

This block turns an integer address offset into a checked virtual address for a capability-protected pipeline. Data accesses go through the default data capability (register 0): the effective address is the capability cursor (base plus offset, modulo 2^64) plus the unsigned request address. Before the address is released, the block checks the capability's tag, its sealed state, the permission that matches the access kind, and the bounds of the access. Instruction fetches take a separate path relative to the program-counter capability. That path checks alignment of the absolute PC and that a 4-byte fetch stays inside the PCC length.

The result is registered and appears one clock after the request, together with an exception class. When a capability fault occurs, an 8-bit cause code and the register number are packed into a 16-bit cause register. Only one fault is reported per access: the highest-priority failing check. Other units can also post a capability cause directly through a raise port. That port is what selects the call/return trap class. Address translation and exception vectoring are done elsewhere.

Top module: `cap_addr_check`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0, `rsp_fault` is 0, `rsp_class` is 0 (none) and `cause_reg` is 0x0000.
- R2: For a data request (`req_kind` 1 = load, 2 = store, 3 = execute-through-data), `rsp_vaddr` one clock later equals ddc_base + ddc_offset + req_addr, modulo 2^64.
- R3: A data request with `ddc_tag` clear faults with code 0x02, whatever the seal, permission and bounds state.
- R4: With the tag set, a sealed data capability faults with code 0x03 ahead of any permission or bounds failure.
- R5: The permission checked follows the kind, with `ddc_perms` bit 0 = execute, bit 1 = load, bit 2 = store. A missing permission gives 0x11 for kind 3, 0x12 for kind 1 and 0x13 for kind 2. This check ranks above bounds.
- R6: A data access faults with code 0x01 if vaddr + size > base + length, or if vaddr < base. The sums are taken without wrapping at 2^64, so a carry out counts against the access. An access ending exactly at base + length passes.
- R7: `req_size` encodes the access size as 1 << req_size bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8).
- R8: For a fetch (`req_kind` 0), `rsp_vaddr` is pcc_base + req_addr. If its two low bits are nonzero, `rsp_class` is 3 (address error) and `cause_reg` is left unchanged.
- R9: An aligned fetch with req_addr + 4 > pcc_length faults with code 0x01 and register number 0xFF. req_addr + 4 equal to pcc_length passes.
- R10: `cause_reg` holds the code in bits 15..8 and the register number in bits 7..0. Data faults report register 0x00. The register changes only on a capability fault and holds its value on clean accesses and on address errors.
- R11: A raise request loads `raise_code` into the cause. Its register field is the zero-extended `raise_regnum` if `raise_has_reg` is set, and 0xFF otherwise. A raise takes precedence over a request in the same cycle.
- R12: `rsp_class` is 2 (call/return trap) for codes 0x05 and 0x06. Every other capability code gives 1. `rsp_fault` is high exactly when `rsp_class` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address request this cycle |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 execute via data capability |
| req_addr | input | 64 | Offset address (PC for fetch) |
| req_size | input | 2 | Log2 of the access size in bytes |
| ddc_tag | input | 1 | Data capability valid tag |
| ddc_sealed | input | 1 | Data capability is sealed |
| ddc_perms | input | 3 | Bit 0 execute, bit 1 load, bit 2 store |
| ddc_base | input | 64 | Data capability base |
| ddc_offset | input | 64 | Data capability offset |
| ddc_length | input | 64 | Data capability length |
| pcc_base | input | 64 | Program-counter capability base |
| pcc_length | input | 64 | Program-counter capability length |
| raise_valid | input | 1 | Post a capability cause directly |
| raise_code | input | 8 | Cause code to post |
| raise_has_reg | input | 1 | The posted cause names a register |
| raise_regnum | input | 5 | Register number for the posted cause |
| rsp_valid | output | 1 | Result valid (one clock after request) |
| rsp_vaddr | output | 64 | Checked virtual address |
| rsp_fault | output | 1 | Result carries an exception |
| rsp_class | output | 2 | 0 none, 1 capability, 2 call/return trap, 3 address error |
| cause_reg | output | 16 | Code in 15..8, register number in 7..0 |

## Verification
The hardest situation to reach is a bounds test that depends on the carry past 2^64. Two cases need it: an access that ends exactly at a limit of 2^64 and must pass, and one that spills a single byte beyond it and must fail. The stimulus places the base at 0xFFFF_FFFF_FFFF_FFF0 with length 0x10, which puts the limit at exactly 2^64. It then walks the cursor plus address across that edge and also adds an address large enough to wrap the 64-bit sum. Priority is reached by faulting several checks at once: a cleared tag with a sealed, permissionless, out-of-bounds capability, then the tag restored, and so on down the chain.

// File: rtl/capchk_pkg.sv
package capchk_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    XC_NONE    = 2'd0,
    XC_CAP     = 2'd1,
    XC_CAPTRAP = 2'd2,
    XC_ADDR    = 2'd3
  } xclass_e;

  typedef enum logic [7:0] {
    CC_NONE         = 8'h00,
    CC_LENGTH       = 8'h01,
    CC_TAG          = 8'h02,
    CC_SEAL         = 8'h03,
    CC_TYPE         = 8'h04,
    CC_CALL         = 8'h05,
    CC_RETURN       = 8'h06,
    CC_TSS_UNDER    = 8'h07,
    CC_USER         = 8'h08,
    CC_TLB_NOSTCAP  = 8'h09,
    CC_INEXACT      = 8'h0A,
    CC_GLOBAL       = 8'h10,
    CC_PERM_EXEC    = 8'h11,
    CC_PERM_LOAD    = 8'h12,
    CC_PERM_STORE   = 8'h13,
    CC_PERM_LDCAP   = 8'h14,
    CC_PERM_STCAP   = 8'h15,
    CC_PERM_STLOCAL = 8'h16,
    CC_PERM_SEAL    = 8'h17,
    CC_PERM_SYSREG  = 8'h18
  } cause_e;

  localparam int PB_EXEC  = 0;
  localparam int PB_LOAD  = 1;
  localparam int PB_STORE = 2;
  localparam int PERM_W   = 3;

  localparam logic [7:0] REG_NONE = 8'hFF;

  function automatic logic [1:0] class_of_code(logic [7:0] code);
    if (code == CC_CALL || code == CC_RETURN) return XC_CAPTRAP;
    return XC_CAP;
  endfunction

endpackage

// File: rtl/capchk_data.sv
module capchk_data
  import capchk_pkg::*;
#(
  parameter int AW  = 64,
  parameter int SZW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          kind,
  input  logic [AW-1:0]       addr,
  input  logic [SZW-1:0]      size_log2,
  input  logic                tag,
  input  logic                sealed,
  input  logic [PERM_W-1:0]   perms,
  input  logic [AW-1:0]       base,
  input  logic [AW-1:0]       offset,
  input  logic [AW-1:0]       length,
  output logic [AW-1:0]       vaddr,
  output logic                fault,
  output logic [7:0]          code
);

  localparam int LW = AW + 1;
  localparam int EW = AW + 2;

  function automatic logic [EW-1:0] span_end(logic [LW-1:0] lo, logic [SZW-1:0] sl);
    return {1'b0, lo} + (EW'(1) << sl);
  endfunction

  function automatic logic perm_granted(logic [1:0] k, logic [PERM_W-1:0] p);
    case (k)
      ACC_LOAD:  return p[PB_LOAD];
      ACC_STORE: return p[PB_STORE];
      default:   return p[PB_EXEC];
    endcase
  endfunction

  function automatic logic [7:0] perm_cause(logic [1:0] k);
    case (k)
      ACC_LOAD:  return CC_PERM_LOAD;
      ACC_STORE: return CC_PERM_STORE;
      default:   return CC_PERM_EXEC;
    endcase
  endfunction

  logic [AW-1:0] cursor;
  logic [LW-1:0] span_lo;
  logic [EW-1:0] span_hi;
  logic [LW-1:0] limit;

  logic chk_tag_bad;
  logic chk_seal_bad;
  logic chk_perm_bad;
  logic chk_below;
  logic chk_over;
  logic chk_bounds_bad;

  assign cursor  = base + offset;
  assign span_lo = {1'b0, cursor} + {1'b0, addr};
  assign span_hi = span_end(span_lo, size_log2);
  assign limit   = {1'b0, base} + {1'b0, length};
  assign vaddr   = span_lo[AW-1:0];

  assign chk_tag_bad    = !tag;
  assign chk_seal_bad   = sealed;
  assign chk_perm_bad   = !perm_granted(kind, perms);
  assign chk_below      = span_lo < {1'b0, base};
  assign chk_over       = span_hi > {1'b0, limit};
  assign chk_bounds_bad = chk_below | chk_over;

  always_comb begin
    fault = 1'b1;
    if (chk_tag_bad)         code = CC_TAG;
    else if (chk_seal_bad)   code = CC_SEAL;
    else if (chk_perm_bad)   code = perm_cause(kind);
    else if (chk_bounds_bad) code = CC_LENGTH;
    else begin
      code  = CC_NONE;
      fault = 1'b0;
    end
  end

  // R3: a cleared tag outranks every other data check
  a_r3_tag_first: assert property (@(posedge clk) disable iff (!rst_n)
    chk_tag_bad |-> (fault && code == CC_TAG));

  // R4: seal outranks permission and bounds once the tag is good
  a_r4_seal_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_tag_bad && chk_seal_bad) |-> code == CC_SEAL);

  // R6: a clean result never reaches past the limit
  a_r6_clean_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (!chk_over && !chk_below));

endmodule

// File: rtl/capchk_fetch.sv
module capchk_fetch #(
  parameter int AW        = 64,
  parameter int FETCH_B   = 4,
  parameter int ALIGN_LSB = 2
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] pcc_base,
  input  logic [AW-1:0] pcc_length,
  output logic [AW-1:0] abs_pc,
  output logic          misaligned,
  output logic          len_bad
);

  localparam int LW = AW + 1;

  function automatic logic [LW-1:0] fetch_end(logic [AW-1:0] p);
    return {1'b0, p} + LW'(FETCH_B);
  endfunction

  assign abs_pc     = pcc_base + pc;
  assign misaligned = |abs_pc[ALIGN_LSB-1:0];
  assign len_bad    = fetch_end(pc) > {1'b0, pcc_length};

endmodule

// File: rtl/capchk_cause.sv
module capchk_cause
  import capchk_pkg::*;
#(
  parameter int RW       = 5,
  parameter int DATA_REG = 0
) (
  input  logic          raise_valid,
  input  logic [7:0]    raise_code,
  input  logic          raise_has_reg,
  input  logic [RW-1:0] raise_regnum,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          data_fault,
  input  logic [7:0]    data_code,
  input  logic          fetch_misal,
  input  logic          fetch_len_bad,
  output logic [1:0]    nxt_class,
  output logic [7:0]    nxt_code,
  output logic [7:0]    nxt_regnum,
  output logic          cause_wr
);

  localparam int PADW = 8 - RW;

  function automatic logic [7:0] widen_reg(logic [RW-1:0] r);
    return {{PADW{1'b0}}, r};
  endfunction

  always_comb begin
    nxt_class  = XC_NONE;
    nxt_code   = CC_NONE;
    nxt_regnum = 8'h00;
    cause_wr   = 1'b0;
    if (raise_valid) begin
      nxt_class  = class_of_code(raise_code);
      nxt_code   = raise_code;
      nxt_regnum = raise_has_reg ? widen_reg(raise_regnum) : REG_NONE;
      cause_wr   = 1'b1;
    end else if (req_valid) begin
      if (req_kind == ACC_FETCH) begin
        if (fetch_misal) begin
          nxt_class = XC_ADDR;
        end else if (fetch_len_bad) begin
          nxt_class  = XC_CAP;
          nxt_code   = CC_LENGTH;
          nxt_regnum = REG_NONE;
          cause_wr   = 1'b1;
        end
      end else if (data_fault) begin
        nxt_class  = class_of_code(data_code);
        nxt_code   = data_code;
        nxt_regnum = widen_reg(RW'(DATA_REG));
        cause_wr   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cap_addr_check.sv
module cap_addr_check
  import capchk_pkg::*;
#(
  parameter int AW       = 64,
  parameter int RW       = 5,
  parameter int SZW      = 2,
  parameter int DATA_REG = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [AW-1:0]     req_addr,
  input  logic [SZW-1:0]    req_size,
  input  logic              ddc_tag,
  input  logic              ddc_sealed,
  input  logic [2:0]        ddc_perms,
  input  logic [AW-1:0]     ddc_base,
  input  logic [AW-1:0]     ddc_offset,
  input  logic [AW-1:0]     ddc_length,
  input  logic [AW-1:0]     pcc_base,
  input  logic [AW-1:0]     pcc_length,
  input  logic              raise_valid,
  input  logic [7:0]        raise_code,
  input  logic              raise_has_reg,
  input  logic [RW-1:0]     raise_regnum,
  output logic              rsp_valid,
  output logic [AW-1:0]     rsp_vaddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_class,
  output logic [15:0]       cause_reg
);

  logic [AW-1:0] data_vaddr;
  logic          data_fault;
  logic [7:0]    data_code;
  logic [AW-1:0] fetch_pc;
  logic          fetch_misal;
  logic          fetch_len_bad;
  logic [1:0]    nxt_class;
  logic [7:0]    nxt_code;
  logic [7:0]    nxt_regnum;
  logic          cause_wr;

  logic          valid_q;
  logic [AW-1:0] vaddr_q;
  logic [1:0]    class_q;
  logic [15:0]   cause_q;
  logic          fetch_q;
  logic          raise_q;

  capchk_data #(.AW(AW), .SZW(SZW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (req_kind),
    .addr      (req_addr),
    .size_log2 (req_size),
    .tag       (ddc_tag),
    .sealed    (ddc_sealed),
    .perms     (ddc_perms),
    .base      (ddc_base),
    .offset    (ddc_offset),
    .length    (ddc_length),
    .vaddr     (data_vaddr),
    .fault     (data_fault),
    .code      (data_code)
  );

  capchk_fetch #(.AW(AW)) u_fetch (
    .pc         (req_addr),
    .pcc_base   (pcc_base),
    .pcc_length (pcc_length),
    .abs_pc     (fetch_pc),
    .misaligned (fetch_misal),
    .len_bad    (fetch_len_bad)
  );

  capchk_cause #(.RW(RW), .DATA_REG(DATA_REG)) u_cause (
    .raise_valid   (raise_valid),
    .raise_code    (raise_code),
    .raise_has_reg (raise_has_reg),
    .raise_regnum  (raise_regnum),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .data_fault    (data_fault),
    .data_code     (data_code),
    .fetch_misal   (fetch_misal),
    .fetch_len_bad (fetch_len_bad),
    .nxt_class     (nxt_class),
    .nxt_code      (nxt_code),
    .nxt_regnum    (nxt_regnum),
    .cause_wr      (cause_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vaddr_q <= '0;
      class_q <= XC_NONE;
      fetch_q <= 1'b0;
      raise_q <= 1'b0;
    end else begin
      valid_q <= req_valid | raise_valid;
      class_q <= nxt_class;
      fetch_q <= req_valid && (req_kind == ACC_FETCH);
      raise_q <= raise_valid;
      if (req_valid) vaddr_q <= (req_kind == ACC_FETCH) ? fetch_pc : data_vaddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= 16'h0000;
    else if (cause_wr) cause_q <= {nxt_code, nxt_regnum};
  end

  assign rsp_valid = valid_q;
  assign rsp_vaddr = vaddr_q;
  assign rsp_class = class_q;
  assign rsp_fault = (class_q != XC_NONE);
  assign cause_reg = cause_q;

  // R10: the cause register only moves when a capability fault is posted
  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> $stable(cause_reg));

  // R8: an address error leaves the cause register untouched
  a_r8_addr_err_keeps_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_class == XC_ADDR) |-> (cause_reg == $past(cause_reg)));

  // R9: fetch length faults name no register
  a_r9_fetch_noreg: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && !raise_q && rsp_class == XC_CAP) |-> (cause_reg[7:0] == REG_NONE));

  // R12: the trap class appears only with a call or return code
  a_r12_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_class == XC_CAPTRAP) |-> (cause_reg[15:8] == CC_CALL || cause_reg[15:8] == CC_RETURN));

  // R12: an exception class is only ever reported with a valid result
  a_r12_fault_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid);

endmodule

// File: tb/test_cap_addr_check.sv
module test_cap_addr_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd1;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_size = 2'd0;
  logic        ddc_tag = 1'b1;
  logic        ddc_sealed = 1'b0;
  logic [2:0]  ddc_perms = 3'b111;
  logic [63:0] ddc_base = 64'h1000;
  logic [63:0] ddc_offset = '0;
  logic [63:0] ddc_length = 64'h100;
  logic [63:0] pcc_base = 64'h2000;
  logic [63:0] pcc_length = 64'h40;
  logic        raise_valid = 1'b0;
  logic [7:0]  raise_code = '0;
  logic        raise_has_reg = 1'b0;
  logic [4:0]  raise_regnum = '0;
  logic        rsp_valid;
  logic [63:0] rsp_vaddr;
  logic        rsp_fault;
  logic [1:0]  rsp_class;
  logic [15:0] cause_reg;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_cause = 16'h0000;

  always #2 clk = ~clk;

  cap_addr_check i_cap_addr_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_size(req_size), .ddc_tag(ddc_tag),
    .ddc_sealed(ddc_sealed), .ddc_perms(ddc_perms), .ddc_base(ddc_base),
    .ddc_offset(ddc_offset), .ddc_length(ddc_length), .pcc_base(pcc_base),
    .pcc_length(pcc_length), .raise_valid(raise_valid), .raise_code(raise_code),
    .raise_has_reg(raise_has_reg), .raise_regnum(raise_regnum),
    .rsp_valid(rsp_valid), .rsp_vaddr(rsp_vaddr), .rsp_fault(rsp_fault),
    .rsp_class(rsp_class), .cause_reg(cause_reg)
  );

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // independent model of the data path: wide integers, no wrap except the cursor
  function automatic logic [7:0] model_data(logic [1:0] k, logic [63:0] a, logic [1:0] sl,
      logic tg, logic sd, logic [2:0] pm, logic [63:0] b, logic [63:0] o, logic [63:0] l);
    logic [63:0]  c64;
    logic [129:0] lo, hi, lim;
    if (!tg) return 8'h02;
    if (sd) return 8'h03;
    if (k == 2'd1 && !pm[1]) return 8'h12;
    if (k == 2'd2 && !pm[2]) return 8'h13;
    if (k == 2'd3 && !pm[0]) return 8'h11;
    c64 = b + o;
    lo  = 130'(c64) + 130'(a);
    hi  = lo + (130'(1) << sl);
    lim = 130'(b) + 130'(l);
    if (hi > lim || lo < 130'(b)) return 8'h01;
    return 8'h00;
  endfunction

  task automatic issue();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic data_case(string req, logic [1:0] k, logic [63:0] a, logic [1:0] sl);
    logic [7:0]  code;
    logic [63:0] vexp;
    req_kind = k; req_addr = a; req_size = sl;
    code = model_data(k, a, sl, ddc_tag, ddc_sealed, ddc_perms, ddc_base, ddc_offset, ddc_length);
    vexp = ddc_base + ddc_offset + a;
    issue();
    if (code != 8'h00) exp_cause = {code, 8'h00};
    check(req, "valid", 64'(rsp_valid), 64'd1);
    check(req, "vaddr", rsp_vaddr, vexp);
    check(req, "class", 64'(rsp_class), (code != 0) ? 64'd1 : 64'd0);
    check("R12", "fault", 64'(rsp_fault), 64'(code != 0));
    check(req, "cause", 64'(cause_reg), 64'(exp_cause));
  endtask

  task automatic fetch_case(string req, logic [63:0] pc, logic [1:0] cls_exp);
    req_kind = 2'd0; req_addr = pc;
    issue();
    if (cls_exp == 2'd1) exp_cause = 16'h01FF;
    check(req, "vaddr", rsp_vaddr, pcc_base + pc);
    check(req, "class", 64'(rsp_class), 64'(cls_exp));
    check("R10", "cause", 64'(cause_reg), 64'(exp_cause));
  endtask

  task automatic t_reset();
    check("R1", "valid", 64'(rsp_valid), 64'd0);
    check("R1", "fault", 64'(rsp_fault), 64'd0);
    check("R1", "class", 64'(rsp_class), 64'd0);
    check("R1", "cause", 64'(cause_reg), 64'd0);
  endtask

  task automatic t_normal();
    ddc_tag = 1; ddc_sealed = 0; ddc_perms = 3'b111;
    ddc_base = 64'h1000; ddc_offset = 64'h10; ddc_length = 64'h100;
    data_case("R2", 2'd1, 64'h20, 2'd3);
    check("R2", "vaddr literal", rsp_vaddr, 64'h1030);
    data_case("R2", 2'd2, 64'hF0, 2'd0);
    data_case("R2", 2'd3, 64'h4, 2'd2);
  endtask

  task automatic t_tag();
    ddc_tag = 0; ddc_sealed = 1; ddc_perms = 3'b000; ddc_offset = 64'h1000;
    data_case("R3", 2'd1, 64'h0, 2'd3);
    check("R3", "cause literal", 64'(cause_reg), 64'h0200);
  endtask

  task automatic t_seal();
    ddc_tag = 1; ddc_sealed = 1; ddc_perms = 3'b000; ddc_offset = 64'h1000;
    data_case("R4", 2'd2, 64'h0, 2'd3);
    check("R4", "cause literal", 64'(cause_reg), 64'h0300);
  endtask

  task automatic t_perm();
    ddc_sealed = 0; ddc_offset = 64'h1000;
    ddc_perms = 3'b101; data_case("R5", 2'd1, 64'h0, 2'd0);
    check("R5", "load code", 64'(cause_reg), 64'h1200);
    ddc_perms = 3'b011; data_case("R5", 2'd2, 64'h0, 2'd0);
    check("R5", "store code", 64'(cause_reg), 64'h1300);
    ddc_perms = 3'b110; data_case("R5", 2'd3, 64'h0, 2'd0);
    check("R5", "exec code", 64'(cause_reg), 64'h1100);
    ddc_perms = 3'b100; ddc_offset = '0;
    data_case("R5", 2'd2, 64'h8, 2'd0);
  endtask

  task automatic t_bounds();
    ddc_perms = 3'b111; ddc_base = 64'h1000; ddc_offset = 0; ddc_length = 64'h40;
    data_case("R6", 2'd1, 64'h38, 2'd3);
    check("R6", "exact fit class", 64'(rsp_class), 64'd0);
    data_case("R6", 2'd1, 64'h39, 2'd3);
    check("R6", "one over cause", 64'(cause_reg), 64'h0100);
    exp_cause = 16'h0000;
    ddc_offset = 64'hFFFF_FFFF_FFFF_FFF0;
    data_case("R6", 2'd1, 64'h0, 2'd0);
    ddc_base = 64'hFFFF_FFFF_FFFF_FFF0; ddc_length = 64'h10; ddc_offset = 64'h8;
    data_case("R6", 2'd1, 64'h0, 2'd3);
    check("R6", "top edge class", 64'(rsp_class), 64'd0);
    data_case("R6", 2'd1, 64'h1, 2'd3);
    data_case("R6", 2'd1, 64'h10, 2'd0);
    check("R6", "wrap vaddr", rsp_vaddr, 64'h8);
  endtask

  task automatic t_size();
    ddc_base = 64'h1000; ddc_offset = 0; ddc_length = 64'h40;
    data_case("R7", 2'd1, 64'h3C, 2'd2);
    data_case("R7", 2'd1, 64'h3C, 2'd3);
    data_case("R7", 2'd2, 64'h3E, 2'd1);
    data_case("R7", 2'd2, 64'h3F, 2'd0);
    data_case("R7", 2'd2, 64'h3F, 2'd1);
    ddc_offset = 64'h4;
    data_case("R10", 2'd1, 64'h0, 2'd0);
    check("R10", "held cause", 64'(cause_reg), 64'h0100);
  endtask

  task automatic t_fetch();
    pcc_base = 64'h2000; pcc_length = 64'h40;
    fetch_case("R8", 64'h6, 2'd3);
    pcc_base = 64'h2002;
    fetch_case("R8", 64'h2, 2'd0);
    pcc_base = 64'h2000;
    fetch_case("R9", 64'h3C, 2'd0);
    fetch_case("R9", 64'h40, 2'd1);
    check("R9", "cause literal", 64'(cause_reg), 64'h01FF);
  endtask

  task automatic t_raise();
    raise_valid = 1; raise_code = 8'h05; raise_has_reg = 1; raise_regnum = 5'd7;
    @(negedge clk); raise_valid = 0;
    check("R11", "cause", 64'(cause_reg), 64'h0507);
    check("R12", "trap class", 64'(rsp_class), 64'd2);
    raise_valid = 1; raise_code = 8'h06; raise_has_reg = 1; raise_regnum = 5'd31;
    @(negedge clk); raise_valid = 0;
    check("R12", "return class", 64'(rsp_class), 64'd2);
    check("R11", "cause", 64'(cause_reg), 64'h061F);
    raise_valid = 1; raise_code = 8'h17; raise_has_reg = 0;
    ddc_tag = 1; ddc_perms = 3'b111; ddc_offset = 0;
    req_kind = 2'd1; req_addr = 64'h0; req_size = 2'd0;
    issue(); raise_valid = 0;
    check("R11", "noreg cause", 64'(cause_reg), 64'h17FF);
    check("R12", "cap class", 64'(rsp_class), 64'd1);
    check("R12", "fault", 64'(rsp_fault), 64'd1);
    exp_cause = 16'h17FF;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_tag();
    t_seal();
    t_perm();
    t_bounds();
    t_size();
    t_fetch();
    t_raise();
    @(negedge clk);
    check("R1", "idle valid", 64'(rsp_valid), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule